// File: doc/BRIEF.md
# Programmable Periodic Interrupt Generator

This block turns a 32768 Hz time base into a periodic event stream for a real-time clock. A single-cycle enable (`tickEn`) marks each 32 kHz tick in the fast system clock domain. A free-running tick counter advances on every tick. An event fires on the tick that brings that counter to a multiple of the selected period. The period is always a power of two, chosen by a 4-bit rate code in which zero switches the generator off and the two smallest codes are remapped onto slow rates.

Each event raises a one-cycle flag-set pulse, which the surrounding status logic uses to set its periodic flag. When the interrupt enable is set, the event also raises a one-cycle interrupt request. When the square-wave enable is set, it raises a one-cycle pulse on the square-wave output; this is a pulse train, not a 50% duty wave. The status register, the bus access and any lost-tick compensation sit outside this block.

Top module: `periodic_irq_gen`

## Requirements
- R1: When `rateCode` is 0, no event occurs: `flagPulse`, `irqReq` and `sqwPulse` stay low.
- R2: When both `intEn` and `sqwEn` are low, no event occurs, whatever the rate code.
- R3: Rate code 1 gives a period of 128 ticks and rate code 2 gives a period of 256 ticks.
- R4: Rate codes 3 to 15 give a period of 2^(code-1) ticks, so code 3 is 4 ticks and code 15 is 16384 ticks.
- R5: The tick counter starts at 0 at reset and advances on every tick, whether or not the generator is enabled. An event falls on the tick that makes the count a multiple of the period, not one full period after enabling.
- R6: Every event gives a `flagPulse`. `irqReq` pulses with it only if `intEn` is high on that tick.
- R7: `sqwPulse` is a single-cycle pulse on an event, and only if `sqwEn` is high on that tick.
- R8: The outputs go high in the clock cycle after the edge that samples the tick and stay high for one cycle. During reset and right after it, all outputs are low.
- R9: A change of rate code or enables makes no event by itself. The new setting applies from the next tick that falls on a boundary of the new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-cycle strobe per 32768 Hz tick |
| rateCode | input | 4 | Rate select code; 0 disables |
| intEn | input | 1 | Periodic interrupt enable |
| sqwEn | input | 1 | Square-wave pulse enable |
| flagPulse | output | 1 | One-cycle request to set the periodic flag |
| irqReq | output | 1 | One-cycle interrupt request |
| sqwPulse | output | 1 | One-cycle square-wave pulse |

## Verification
The assertions assume that `tickEn` is never high on two clock cycles in a row, which is what a 32 kHz strobe in a much faster clock looks like. The one-cycle pulse width check depends on this. The stimulus always follows a tick with at least two idle cycles. It changes the rate code and the enables only on cycles without a tick, so every setting is stable at the edge that samples a tick. Within that envelope, the bench changes codes and enables at arbitrary counter phases to exercise the boundary alignment and the absence of events when a setting changes.

// File: rtl/periodic_irq_gen_pkg.sv
package periodic_irq_gen_pkg;

  localparam int PG_CODE_W = 4;

  // Strobes from control to datapath for one clock cycle.
  typedef struct packed {
    logic                 advance;    // a 32 kHz tick is present this cycle
    logic                 armed;      // generator enabled for this tick
    logic [PG_CODE_W-1:0] periodLog;  // log2 of the period in ticks
  } pgStrobe_t;

endpackage

// File: rtl/periodic_irq_gen_ctrl.sv
module periodic_irq_gen_ctrl
  import periodic_irq_gen_pkg::*;
#(
  parameter int CODE1_LOG = 7,
  parameter int CODE2_LOG = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tickEn,
  input  logic [PG_CODE_W-1:0] rateCode,
  input  logic                 intEn,
  input  logic                 sqwEn,
  input  logic                 boundaryHit,
  output pgStrobe_t            strobe,
  output logic                 flagPulse,
  output logic                 irqReq,
  output logic                 sqwPulse
);

  logic [PG_CODE_W-1:0] periodLog;
  logic                 codeLive;

  always_comb begin
    codeLive = (rateCode != '0);
    unique case (rateCode)
      PG_CODE_W'(0): periodLog = '0;
      PG_CODE_W'(1): periodLog = PG_CODE_W'(CODE1_LOG);
      PG_CODE_W'(2): periodLog = PG_CODE_W'(CODE2_LOG);
      default:       periodLog = rateCode - PG_CODE_W'(1);
    endcase
  end

  always_comb begin
    strobe.advance   = tickEn;
    strobe.armed     = codeLive && (intEn || sqwEn);
    strobe.periodLog = periodLog;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagPulse <= 1'b0;
      irqReq    <= 1'b0;
      sqwPulse  <= 1'b0;
    end else begin
      flagPulse <= boundaryHit;
      irqReq    <= boundaryHit && intEn;
      sqwPulse  <= boundaryHit && sqwEn;
    end
  end

endmodule

// File: rtl/periodic_irq_gen_dp.sv
module periodic_irq_gen_dp
  import periodic_irq_gen_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic      clk,
  input  logic      rstN,
  input  pgStrobe_t strobe,
  output logic      boundaryHit
);

  logic [CNT_W-1:0] tickCount;
  logic [CNT_W-1:0] nextCount;
  logic [CNT_W-1:0] periodMask;

  assign nextCount = tickCount + CNT_W'(1);

  // Bit g of the mask is set when it lies below the period exponent.
  for (genvar g = 0; g < CNT_W; g++) begin : g_mask
    assign periodMask[g] = (g < int'(strobe.periodLog));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCount <= '0;
    end else if (strobe.advance) begin
      tickCount <= nextCount;
    end
  end

  assign boundaryHit = strobe.advance && strobe.armed &&
                       ((nextCount & periodMask) == '0);

endmodule

// File: rtl/periodic_irq_gen.sv
module periodic_irq_gen
  import periodic_irq_gen_pkg::*;
#(
  parameter int CNT_W     = 14,
  parameter int CODE1_LOG = 7,
  parameter int CODE2_LOG = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tickEn,
  input  logic [PG_CODE_W-1:0] rateCode,
  input  logic                 intEn,
  input  logic                 sqwEn,
  output logic                 flagPulse,
  output logic                 irqReq,
  output logic                 sqwPulse
);

  pgStrobe_t strobe;
  logic      boundaryHit;

  periodic_irq_gen_ctrl #(
    .CODE1_LOG(CODE1_LOG),
    .CODE2_LOG(CODE2_LOG)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .tickEn     (tickEn),
    .rateCode   (rateCode),
    .intEn      (intEn),
    .sqwEn      (sqwEn),
    .boundaryHit(boundaryHit),
    .strobe     (strobe),
    .flagPulse  (flagPulse),
    .irqReq     (irqReq),
    .sqwPulse   (sqwPulse)
  );

  periodic_irq_gen_dp #(
    .CNT_W(CNT_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .boundaryHit(boundaryHit)
  );

endmodule

// File: rtl/periodic_irq_gen_chk.sv
module periodic_irq_gen_chk (
  input logic       clk,
  input logic       rstN,
  input logic       tickEn,
  input logic [3:0] rateCode,
  input logic       intEn,
  input logic       sqwEn,
  input logic       flagPulse,
  input logic       irqReq,
  input logic       sqwPulse
);

  AST_CODE_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (rateCode == 4'd0) |=> !flagPulse && !irqReq && !sqwPulse); // R1

  AST_NO_ENABLE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (!intEn && !sqwEn) |=> !flagPulse); // R2

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!intEn) |=> !irqReq); // R6

  AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> flagPulse); // R6

  AST_SQW_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!sqwEn) |=> !sqwPulse); // R7

  AST_SQW_WITH_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    sqwPulse |-> flagPulse); // R7

  AST_EVENT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn) |=> !flagPulse); // R9

  AST_SINGLE_CYCLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    flagPulse |=> !flagPulse); // R8

endmodule

bind periodic_irq_gen periodic_irq_gen_chk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .tickEn   (tickEn),
  .rateCode (rateCode),
  .intEn    (intEn),
  .sqwEn    (sqwEn),
  .flagPulse(flagPulse),
  .irqReq   (irqReq),
  .sqwPulse (sqwPulse)
);

// File: tb/periodic_irq_gen_tb.sv
module periodic_irq_gen_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic [3:0] rateCode = 4'd0;
  logic       intEn = 1'b0;
  logic       sqwEn = 1'b0;
  logic       flagPulse, irqReq, sqwPulse;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  periodic_irq_gen dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .rateCode(rateCode),
    .intEn(intEn), .sqwEn(sqwEn),
    .flagPulse(flagPulse), .irqReq(irqReq), .sqwPulse(sqwPulse)
  );

  // Reference model
  longint refCount = 0;
  longint tickTotal = 0;
  bit expFlag = 0, expIrq = 0, expSqw = 0;
  bit modelOn = 0;
  int flagSeen = 0, irqSeen = 0, sqwSeen = 0;

  function automatic longint refPeriod(input logic [3:0] code);
    if (code == 4'd1) return 128;     // R3
    if (code == 4'd2) return 256;     // R3
    return longint'(1) << (code - 1); // R4
  endfunction

  function automatic string codeTag(input logic [3:0] code);
    if (code == 4'd0) return "R1";
    if (code <= 4'd2) return "R3";
    return "R4";
  endfunction

  always @(posedge clk) begin
    bit hit;
    hit = 0;
    if (!rstN) begin
      refCount = 0;
    end else if (tickEn) begin
      refCount = refCount + 1;
      if (rateCode != 0 && (intEn || sqwEn) && (refCount % refPeriod(rateCode)) == 0)
        hit = 1;
    end
    expFlag <= hit;
    expIrq  <= hit && intEn;
    expSqw  <= hit && sqwEn;
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && modelOn) begin
      check((!intEn && !sqwEn) ? "R2" : codeTag(rateCode), "flagPulse", flagPulse, expFlag);
      check("R6", "irqReq", irqReq, expIrq);
      check("R7", "sqwPulse", sqwPulse, expSqw);
    end
    if (rstN) begin
      flagSeen += flagPulse;
      irqSeen  += irqReq;
      sqwSeen  += sqwPulse;
    end
  end

  task automatic ticks(input longint n);
    for (longint i = 0; i < n; i++) begin
      @(negedge clk) tickEn = 1'b1;
      tickTotal++;
      @(negedge clk) tickEn = 1'b0;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic setup(input logic [3:0] code, input logic ie, input logic se);
    @(negedge clk);
    rateCode = code; intEn = ie; sqwEn = se;
  endtask

  task automatic countedRun(input string tag, input logic [3:0] code,
                            input logic ie, input logic se, input longint n);
    int f0, i0, s0;
    longint exp;
    setup(code, ie, se);
    f0 = flagSeen; i0 = irqSeen; s0 = sqwSeen;
    ticks(n);
    exp = (code == 0 || (!ie && !se)) ? 0 : n / refPeriod(code);
    check(tag, "event count", flagSeen - f0, int'(exp));
    check("R6", "irq count", irqSeen - i0, ie ? int'(exp) : 0);
    check("R7", "sqw count", sqwSeen - s0, se ? int'(exp) : 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int f0;
    longint k;
    // R8: reset state
    rateCode = 4'd3; intEn = 1; sqwEn = 1;
    repeat (2) @(negedge clk);
    tickEn = 1'b1; @(negedge clk); tickEn = 1'b0;
    repeat (2) @(negedge clk);
    check("R8", "flagPulse in reset", flagPulse, 0);
    check("R8", "irqReq in reset", irqReq, 0);
    check("R8", "sqwPulse in reset", sqwPulse, 0);
    rateCode = 4'd0; intEn = 0; sqwEn = 0;
    rstN = 1'b1;
    modelOn = 1;
    @(negedge clk);
    check("R8", "flagPulse after reset", flagPulse, 0);

    countedRun("R1", 4'd0, 1, 1, 40);
    countedRun("R2", 4'd3, 0, 0, 40);
    countedRun("R4", 4'd3, 1, 1, 40);
    countedRun("R4", 4'd4, 1, 0, 64);
    countedRun("R6", 4'd5, 0, 1, 64);
    countedRun("R3", 4'd1, 1, 1, 256);
    countedRun("R3", 4'd2, 1, 0, 512);

    // R8: exact pulse timing after a boundary tick
    setup(4'd3, 1, 1);
    k = 4 - (tickTotal % 4);
    if (k > 1) ticks(k - 1);
    @(negedge clk) tickEn = 1'b1; tickTotal++;
    @(negedge clk) tickEn = 1'b0;
    check("R8", "pulse cycle after tick", flagPulse, 1);
    @(negedge clk);
    check("R8", "pulse width one cycle", flagPulse, 0);
    @(negedge clk);

    // R5: counter runs while disabled, first event on a multiple of 16
    setup(4'd0, 0, 0);
    ticks(37);
    setup(4'd5, 1, 0);
    k = 16 - (tickTotal % 16);
    f0 = flagSeen;
    if (k > 1) ticks(k - 1);
    check("R5", "no event before boundary", flagSeen - f0, 0);
    ticks(1);
    check("R5", "event on boundary", flagSeen - f0, 1);

    // R9: switching settings on a boundary-aligned count makes no event
    setup(4'd0, 0, 0);
    k = 8 - (tickTotal % 8);
    if (k < 8) ticks(k);
    f0 = flagSeen;
    setup(4'd4, 1, 1);
    repeat (6) @(negedge clk);
    setup(4'd3, 0, 1);
    repeat (6) @(negedge clk);
    check("R9", "no event from setting change", flagSeen - f0, 0);
    ticks(8);
    check("R9", "new rate from next boundary", flagSeen - f0, 2);

    // R7 and R4 at the slowest rate
    countedRun("R7", 4'd6, 0, 1, 96);
    countedRun("R4", 4'd15, 1, 1, 16384);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule